// File: doc/BRIEF.md
# Dual-Bridge PWM Current Chopper Controller

This block is the digital half of a two-winding stepper current regulator. Each of two H-bridges is steered by a direction input and an on/off input. The block turns these into four switch enables per bridge: an upper and a lower switch on each of the two legs. It then chops the upper switch so that the winding current stays at a limit set by an external comparator. That comparator result arrives asynchronously on a per-bridge trip input and passes through a two-flop synchronizer.

A single free-running counter produces one tick every `PERIOD_CYC` cycles. That tick sets the source-enable latch of both bridges in the same cycle. A trip that survives blanking clears only the latch of its own bridge. This turns off only that bridge's upper switch, and the lower switch stays on so the current recirculates and decays. Trips are discarded for `BLANK_CYC` cycles after a source turn-on, which hides the recovery spike. They are also discarded for `SWITCH_BLANK_CYC` cycles after a direction or on/off change switches the bridge outputs. All intervals are parameters in clock cycles. At a 50 MHz clock the defaults of 2000, 65 and 50 give a 25 kHz chop rate, 1.3 µs of turn-on blanking and 1 µs of switch blanking.

Top module: `dual_chopper`

## Requirements
- R1: While reset is high and until an on/off input is raised, all four enables of every bridge are 0. Reset leaves both source latches set, so the first enable turns the upper switch on without waiting for a tick.
- R2: When `enable_i[i]` is 0, all four enables of bridge i are 0 from the clock edge after the input is sampled.
- R3: With bridge i enabled and its latch set, `phase_i[i]`=1 drives `hs_a_o[i]` and `ls_b_o[i]` high, and `phase_i[i]`=0 drives `hs_b_o[i]` and `ls_a_o[i]` high. Upper and lower of one leg are never high together.
- R4: An unblanked trip clears the latch. The conducting upper switch goes low on the third clock edge after `trip_i[i]` is first sampled high, and the lower switch of the other leg stays high.
- R5: A trip on one bridge never changes the latch or any enable of the other bridge.
- R6: One shared tick every `PERIOD_CYC` cycles sets the latches of both bridges in the same cycle, so cleared upper switches of both bridges come back on in the same cycle.
- R7: After a tick turns a cleared source back on, trips are ignored for `BLANK_CYC` cycles. With the trip held high, the upper switch stays on for exactly `BLANK_CYC`+1 cycles.
- R8: A change of `phase_i[i]` while enabled, or a change of `enable_i[i]`, starts a `SWITCH_BLANK_CYC` window on that bridge. With the trip held high from the change, the new upper switch stays on for exactly `SWITCH_BLANK_CYC`+1 cycles.
- R9: A trip that is seen only inside a blanking window is discarded and not held. The source stays on after the window closes.
- R10: A rising `enable_i[i]` sets the latch of bridge i at once, even after a trip cleared it, and starts blanking for the longer of the two windows.
- R11: When the trip input comes from a current that ramps up while the upper switch is on and down while it is off, the current reaches the limit and overshoots it by no more than `BLANK_CYC`+3 steps. The source is re-enabled once per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_i | input | N_BR | Direction per bridge (1: leg A sources) |
| enable_i | input | N_BR | Bridge on/off per bridge |
| trip_i | input | N_BR | Asynchronous current-limit comparator result per bridge |
| hs_a_o | output | N_BR | Upper switch enable, leg A |
| ls_a_o | output | N_BR | Lower switch enable, leg A |
| hs_b_o | output | N_BR | Upper switch enable, leg B |
| ls_b_o | output | N_BR | Lower switch enable, leg B |

## Verification
A wrong latch state shows on the upper-switch enables. A lost clear keeps a source on past the trip latency of three edges. A missed set leaves it off through the tick cycle, and this appears within one `PERIOD_CYC`. A blanking counter that is too short, too long or holds a trip shows as an upper-switch on-time that differs from the window plus one. A held trip shows as a clear that lands after the window has closed. Any of these faults is visible within one window length of the event that started it. A tick that reaches only one bridge appears as unequal upper-switch enables in the tick cycle.

// File: rtl/chop_pkg.sv
package chop_pkg;

    // Default timing in clock cycles (50 MHz clock assumed)
    localparam int DEF_PERIOD_CYC       = 2000;
    localparam int DEF_BLANK_CYC        = 65;
    localparam int DEF_SWITCH_BLANK_CYC = 50;
    localparam int DEF_N_BR             = 2;

    // Switch enables of one H-bridge
    typedef struct packed {
        logic hs_a;
        logic ls_a;
        logic hs_b;
        logic ls_b;
    } gate_t;

    localparam gate_t GATES_OFF = '{hs_a: 1'b0, ls_a: 1'b0, hs_b: 1'b0, ls_b: 1'b0};

    // Diagonal selection: phase 1 sources leg A and sinks leg B.
    function automatic gate_t gate_decode(input logic en, input logic ph, input logic src);
        gate_t g;
        g = GATES_OFF;
        if (en) begin
            g.hs_a = ph & src;
            g.ls_b = ph;
            g.hs_b = ~ph & src;
            g.ls_a = ~ph;
        end
        return g;
    endfunction

    function automatic int umax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/chop_sync.sv
module chop_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    logic [N-1:0] stage1_q;
    logic [N-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/chop_osc.sv
module chop_osc #(
    parameter int PERIOD_CYC = chop_pkg::DEF_PERIOD_CYC
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int CW = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/chop_bridge.sv
module chop_bridge
    import chop_pkg::*;
#(
    parameter int BLANK_CYC        = DEF_BLANK_CYC,
    parameter int SWITCH_BLANK_CYC = DEF_SWITCH_BLANK_CYC
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick_i,
    input  logic  phase_i,
    input  logic  enable_i,
    input  logic  trip_s_i,
    output gate_t gate_o,
    output logic  src_on_o,
    output logic  blank_o
);
    localparam int BMAX = umax(umax(BLANK_CYC, SWITCH_BLANK_CYC), 1);
    localparam int BW   = $clog2(BMAX + 1);
    localparam logic [BW-1:0] LD_ON  = BW'(BLANK_CYC);
    localparam logic [BW-1:0] LD_SW  = BW'(SWITCH_BLANK_CYC);
    localparam logic [BW-1:0] LD_MAX = BW'(umax(BLANK_CYC, SWITCH_BLANK_CYC));

    logic          en_q;
    logic          ph_q;
    logic          src_q;
    logic [BW-1:0] blk_q;

    logic          en_rise;
    logic          sw_chg;
    logic          set_ev;
    logic          turn_on;
    logic          blanked;
    logic          clr_ev;
    logic          src_d;
    logic [BW-1:0] blk_d;

    always_comb begin
        en_rise = enable_i & ~en_q;
        sw_chg  = (enable_i ^ en_q) | (enable_i & (phase_i ^ ph_q));
        set_ev  = tick_i | en_rise;
        turn_on = set_ev & enable_i & (~src_q | en_rise);
        blanked = (blk_q != '0);
        clr_ev  = trip_s_i & ~blanked & en_q & src_q;

        if (set_ev) begin
            src_d = 1'b1;
        end else if (clr_ev) begin
            src_d = 1'b0;
        end else begin
            src_d = src_q;
        end

        if (turn_on && sw_chg) begin
            blk_d = LD_MAX;
        end else if (turn_on) begin
            blk_d = LD_ON;
        end else if (sw_chg) begin
            blk_d = LD_SW;
        end else if (blanked) begin
            blk_d = blk_q - 1'b1;
        end else begin
            blk_d = blk_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            ph_q  <= 1'b0;
            src_q <= 1'b1;
            blk_q <= '0;
        end else begin
            en_q  <= enable_i;
            ph_q  <= phase_i;
            src_q <= src_d;
            blk_q <= blk_d;
        end
    end

    assign gate_o   = gate_decode(en_q, ph_q, src_q);
    assign src_on_o = src_q;
    assign blank_o  = blanked;
endmodule

// File: rtl/dual_chopper.sv
module dual_chopper
    import chop_pkg::*;
#(
    parameter int N_BR             = DEF_N_BR,
    parameter int PERIOD_CYC       = DEF_PERIOD_CYC,
    parameter int BLANK_CYC        = DEF_BLANK_CYC,
    parameter int SWITCH_BLANK_CYC = DEF_SWITCH_BLANK_CYC
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_BR-1:0] phase_i,
    input  logic [N_BR-1:0] enable_i,
    input  logic [N_BR-1:0] trip_i,
    output logic [N_BR-1:0] hs_a_o,
    output logic [N_BR-1:0] ls_a_o,
    output logic [N_BR-1:0] hs_b_o,
    output logic [N_BR-1:0] ls_b_o
);
    logic            osc_tick;
    logic [N_BR-1:0] trip_s;
    logic [N_BR-1:0] src_on;
    logic [N_BR-1:0] blank_act;
    gate_t           gates [N_BR];

    chop_osc #(
        .PERIOD_CYC(PERIOD_CYC)
    ) u_osc (
        .clk    (clk),
        .rst    (rst),
        .tick_o (osc_tick)
    );

    chop_sync #(
        .N(N_BR)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (trip_i),
        .sync_o  (trip_s)
    );

    for (genvar i = 0; i < N_BR; i++) begin : g_br
        chop_bridge #(
            .BLANK_CYC        (BLANK_CYC),
            .SWITCH_BLANK_CYC (SWITCH_BLANK_CYC)
        ) u_br (
            .clk      (clk),
            .rst      (rst),
            .tick_i   (osc_tick),
            .phase_i  (phase_i[i]),
            .enable_i (enable_i[i]),
            .trip_s_i (trip_s[i]),
            .gate_o   (gates[i]),
            .src_on_o (src_on[i]),
            .blank_o  (blank_act[i])
        );

        assign hs_a_o[i] = gates[i].hs_a;
        assign ls_a_o[i] = gates[i].ls_a;
        assign hs_b_o[i] = gates[i].hs_b;
        assign ls_b_o[i] = gates[i].ls_b;
    end
endmodule

// File: rtl/dual_chopper_chk.sv
module dual_chopper_chk #(
    parameter int N_BR = 2
) (
    input logic            clk,
    input logic            rst,
    input logic [N_BR-1:0] enable_i,
    input logic [N_BR-1:0] hs_a_o,
    input logic [N_BR-1:0] ls_a_o,
    input logic [N_BR-1:0] hs_b_o,
    input logic [N_BR-1:0] ls_b_o,
    input logic            tick,
    input logic [N_BR-1:0] trip_s,
    input logic [N_BR-1:0] src_on,
    input logic [N_BR-1:0] blank_act
);
    // R3: never both switches of one leg
    a_r3_leg_exclusive: assert property (@(posedge clk) disable iff (rst)
        ((hs_a_o & ls_a_o) | (hs_b_o & ls_b_o)) == '0);

    // R2: an input sampled low forces the bridge off
    a_r2_disabled_off: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((hs_a_o | ls_a_o | hs_b_o | ls_b_o) & ~$past(enable_i)) == '0);

    // R6: the shared tick sets every latch
    a_r6_tick_sets_all: assert property (@(posedge clk) disable iff (rst)
        tick |=> (&src_on));

    for (genvar i = 0; i < N_BR; i++) begin : g_chk
        // R4 / R5: a latch only clears after its own synchronized trip
        a_r5_own_trip_only: assert property (@(posedge clk) disable iff (rst)
            $fell(src_on[i]) |-> $past(trip_s[i]));

        // R7 / R9: no clear while blanked
        a_r7_blank_holds: assert property (@(posedge clk) disable iff (rst)
            (blank_act[i] && src_on[i]) |=> src_on[i]);
    end
endmodule

bind dual_chopper dual_chopper_chk #(.N_BR(N_BR)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .enable_i  (enable_i),
    .hs_a_o    (hs_a_o),
    .ls_a_o    (ls_a_o),
    .hs_b_o    (hs_b_o),
    .ls_b_o    (ls_b_o),
    .tick      (osc_tick),
    .trip_s    (trip_s),
    .src_on    (src_on),
    .blank_act (blank_act)
);

// File: tb/dual_chopper_test.sv
module dual_chopper_test;
    localparam int N_BR   = 2;
    localparam int PER    = 40;
    localparam int BLK    = 6;
    localparam int SWB    = 4;
    localparam int LIMIT  = 30;
    localparam int WD_MAX = 20000;

    // {enable[1:0], phase[1:0], hs_a, ls_a, hs_b, ls_b}
    localparam int NV = 6;
    localparam logic [11:0] VEC [NV] = '{
        12'b00_11_00_00_00_00,
        12'b11_11_11_00_00_11,
        12'b11_00_00_11_11_00,
        12'b01_10_00_01_01_00,
        12'b10_10_10_00_00_10,
        12'b11_01_01_10_10_01
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N_BR-1:0] phase_i = '0;
    logic [N_BR-1:0] enable_i = '0;
    logic [N_BR-1:0] trip_i = '0;
    logic [N_BR-1:0] hs_a_o, ls_a_o, hs_b_o, ls_b_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    dual_chopper #(
        .N_BR(N_BR), .PERIOD_CYC(PER), .BLANK_CYC(BLK), .SWITCH_BLANK_CYC(SWB)
    ) uut (
        .clk(clk), .rst(rst), .phase_i(phase_i), .enable_i(enable_i), .trip_i(trip_i),
        .hs_a_o(hs_a_o), .ls_a_o(ls_a_o), .hs_b_o(hs_b_o), .ls_b_o(ls_b_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Clears bridge 0 via a trip, then returns at the negedge right after the next tick.
    task automatic align_tick();
        trip_i[0] = 1'b1;
        do @(negedge clk); while (hs_a_o[0]);
        trip_i[0] = 1'b0;
        do @(negedge clk); while (!hs_a_o[0]);
    endtask

    initial begin : wd
        for (int c = 0; c < WD_MAX; c++) begin
            @(posedge clk);
            if (done) disable wd;
        end
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int ok;
        int peak;
        int rises;
        int cur [N_BR];
        logic prev_hs;

        tick_n(3);
        chk("R1 reset gates", {hs_a_o, ls_a_o, hs_b_o, ls_b_o}, '0);
        rst = 1'b0;
        tick_n(3);
        chk("R1 idle after reset", {hs_a_o, ls_a_o, hs_b_o, ls_b_o}, '0);

        // R2 / R3 table; R1: first enable sources at once from the reset-set latch
        for (int v = 0; v < NV; v++) begin
            enable_i = VEC[v][11:10];
            phase_i  = VEC[v][9:8];
            tick_n(2);
            chk($sformatf("R2/R3 vector %0d", v),
                {hs_a_o, ls_a_o, hs_b_o, ls_b_o}, VEC[v][7:0]);
        end

        // R7, R6 period, R5 independence
        phase_i  = 2'b11;
        enable_i = 2'b11;
        tick_n(3);
        align_tick();
        trip_i[0] = 1'b1;
        ok = 1;
        for (int k = 1; k <= 47; k++) begin
            @(negedge clk);
            if (hs_a_o[0] !== ((k <= BLK) || (k >= PER && k <= PER + BLK))) begin
                ok = 0;
                $display("FAIL R7 k=%0d actual=%0b expected=%0b", k, hs_a_o[0], !hs_a_o[0]);
            end
            if (hs_a_o[1] !== 1'b1) ok = 0;
        end
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R5/R6/R7 on-time window actual=mismatch expected=match");
        end
        chk("R4 sink held during chop", ls_b_o[0], 1'b1);
        chk("R5 other bridge untouched", {hs_a_o[1], ls_b_o[1]}, 2'b11);

        // R6: both cleared, both return in the same cycle
        trip_i = 2'b11;
        do @(negedge clk); while (hs_a_o[0] || hs_a_o[1]);
        trip_i = 2'b00;
        ok = 1;
        do begin
            @(negedge clk);
            if (hs_a_o[0] !== hs_a_o[1]) ok = 0;
        end while (!hs_a_o[0]);
        chk("R6 joint set", ok, 1);
        chk("R6 both on", hs_a_o, 2'b11);

        // R8 switch blanking and R4 latency; k counted from the tick above
        tick_n(10);
        phase_i[0] = 1'b0;
        trip_i[0]  = 1'b1;
        tick_n(5);
        chk("R8 source on through switch blank", hs_b_o[0], 1'b1);
        tick_n(1);
        chk("R8 cleared after switch blank", hs_b_o[0], 1'b0);
        chk("R4 sink stays on", ls_a_o[0], 1'b1);
        chk("R5 bridge 1 unaffected", hs_a_o[1], 1'b1);
        trip_i[0] = 1'b0;

        // R10 enable rise sets latch; R9 trip inside window discarded
        tick_n(2);
        enable_i[0] = 1'b0;
        tick_n(1);
        chk("R2 disabled bridge off", {hs_a_o[0], ls_a_o[0], hs_b_o[0], ls_b_o[0]}, 4'b0000);
        tick_n(1);
        enable_i[0] = 1'b1;
        tick_n(1);
        chk("R10 latch set by enable", hs_b_o[0], 1'b1);
        tick_n(1);
        trip_i[0] = 1'b1;
        tick_n(2);
        trip_i[0] = 1'b0;
        tick_n(8);
        chk("R9 blanked trip not held", hs_b_o[0], 1'b1);

        // R11 closed loop with a current model
        phase_i  = 2'b11;
        enable_i = 2'b11;
        for (int b = 0; b < N_BR; b++) cur[b] = 0;
        peak  = 0;
        rises = 0;
        prev_hs = hs_a_o[0];
        for (int c = 0; c < 10 * PER; c++) begin
            @(negedge clk);
            for (int b = 0; b < N_BR; b++) begin
                if (hs_a_o[b]) cur[b]++;
                else if (ls_b_o[b] && cur[b] > 0) cur[b]--;
                trip_i[b] = (cur[b] >= LIMIT);
                if (cur[b] > peak) peak = cur[b];
            end
            if (hs_a_o[0] && !prev_hs) rises++;
            prev_hs = hs_a_o[0];
        end
        trip_i = '0;
        chk("R11 limit reached", (peak >= LIMIT), 1);
        chk("R11 overshoot bound", (peak <= LIMIT + BLK + 3), 1);
        chk("R11 one re-enable per period", (rises >= 8 && rises <= 10), 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule